// File: doc/BRIEF.md
# Burst Frame Assembler

This block turns already-encoded payload frames into the symbol stream of a transmit burst. Frames enter as fixed-size groups of words through a valid/ready write port and are held in an elastic buffer sized for a whole number of frames. A symbol-rate strobe paces the output: each strobe advances the stream by one symbol, and the block reports the current symbol bit, a transmit-enable level and a code that names the field the symbol belongs to.

A burst opens with one lead symbol that only raises transmit enable. It continues with a run of zero symbols, then a run of alternating symbols starting with 0, then a fixed 32-bit sync word, and then the payload. When the next frame is fully in the buffer by the time the last payload symbol ends, it is appended after only a sync word. Otherwise the burst closes and transmit enable drops. A force input holds transmit enable high for test. The write port follows the usual rule: a word moves on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low while the buffer is full, and the source must then hold its word until it is taken.

Top module: `burst_assembler`

## Requirements
- R1: After reset `field` is 0 (idle), `sym_bit` is 0, `tx_en` equals `tx_force` and `in_ready` is 1.
- R2: A burst shows, one per strobe, field code 1 (lead, bit 0), then PRE0_LEN symbols of code 2 with bit 0, then PRE1_LEN symbols of code 3 with bits 0,1,0,1,..., then 32 symbols of code 4 carrying 0x1ACFFC1D most significant bit first.
- R3: After the sync word come FRAME_WORDS*WORD_W symbols of code 5. They carry the frame's words in write order, each word most significant bit first.
- R4: If another frame is complete before the strobe that ends the last payload symbol, that strobe moves straight to code 4 (sync) with `tx_en` still high, and no preamble is sent.
- R5: If no complete frame is waiting at that strobe, `field` returns to 0 and `tx_en` falls, unless `tx_force` is set. A frame that completes later starts a new burst beginning with code 1.
- R6: A frame counts as available only once its last word has been accepted. A partly written frame never starts a burst.
- R7: While idle, the first strobe after a complete frame is available moves `field` to code 1.
- R8: `field` and `sym_bit` change only at a clock edge where `sym_stb` is high.
- R9: `in_ready` is 0 while the buffer holds BUF_FRAMES*FRAME_WORDS words. A word offered during that time is not accepted, and buffered data is not disturbed.
- R10: `tx_en` is 1 exactly when `field` is nonzero or `tx_force` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Write word is valid |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | WORD_W | Encoded payload word |
| sym_stb | input | 1 | Advance one symbol |
| tx_force | input | 1 | Hold transmit enable high |
| sym_bit | output | 1 | Current symbol bit |
| tx_en | output | 1 | Transmit enable |
| field | output | 3 | Field code of the current symbol (0 idle, 1 lead, 2 zeros, 3 toggle, 4 sync, 5 payload) |

## Verification
The bench completes a second frame one strobe before the end of the current payload. A design that made the append decision too early or too late would send a fresh preamble or close the burst instead of going straight to sync. It also completes a frame only after a burst has closed, which must reopen with the lead symbol and not a bare sync word. It offers a word into a full buffer, which a design that ignores fullness would write over unsent data. It strobes after only part of a frame has been written, which a design counting words instead of whole frames would wrongly start transmitting. Pauses in the strobe inside a burst expose any output that moves without a strobe.

// File: rtl/burst_asm_pkg.sv
package burst_asm_pkg;
  typedef enum logic [2:0] {
    FLD_IDLE   = 3'd0,
    FLD_LEAD   = 3'd1,
    FLD_ZERO   = 3'd2,
    FLD_TOGGLE = 3'd3,
    FLD_SYNC   = 3'd4,
    FLD_DATA   = 3'd5
  } fld_e;
endpackage

// File: rtl/burst_fifo.sv
module burst_fifo #(
  parameter int WORD_W      = 16,
  parameter int FRAME_WORDS = 65,
  parameter int BUF_FRAMES  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_word,
  input  logic              take,
  output logic              frame_avail
);
  localparam int DEPTH = FRAME_WORDS * BUF_FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int OW    = $clog2(DEPTH + 1);
  localparam int FW    = $clog2(FRAME_WORDS + 1);
  localparam int NW    = $clog2(BUF_FRAMES + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [OW-1:0]     occ;
  logic [FW-1:0]     fill;
  logic [NW-1:0]     nfull;
  logic              wr_fire, frame_done;

  assign wr_ready    = (occ != OW'(DEPTH));
  assign wr_fire     = wr_valid && wr_ready;
  assign frame_done  = wr_fire && (fill == FW'(FRAME_WORDS - 1));
  assign rd_word     = mem[rd_ptr];
  assign frame_avail = (nfull != '0);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      fill   <= '0;
      nfull  <= '0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        fill   <= frame_done ? '0 : fill + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_fire, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      case ({frame_done, take})
        2'b10:   nfull <= nfull + 1'b1;
        2'b01:   nfull <= nfull - 1'b1;
        default: nfull <= nfull;
      endcase
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_asm_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          FRAME_WORDS = 65,
  parameter int          PRE0_LEN    = 800,
  parameter int          PRE1_LEN    = 800,
  parameter logic [31:0] SYNC_WORD   = 32'h1ACFFC1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_stb,
  input  logic              frame_avail,
  input  logic [WORD_W-1:0] rd_word,
  output logic              pop,
  output logic              take,
  output fld_e              fld,
  output logic              sym_bit
);
  localparam int FRAME_BITS = FRAME_WORDS * WORD_W;
  localparam int M1   = (PRE0_LEN > PRE1_LEN) ? PRE0_LEN : PRE1_LEN;
  localparam int M2   = (M1 > FRAME_BITS) ? M1 : FRAME_BITS;
  localparam int MAXC = (M2 > 32) ? M2 : 32;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int WIW  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [CW-1:0]     cnt;
  logic [WIW-1:0]    widx;
  logic              last_bit, pre1_end;
  logic [31:0]       sync_sh;
  logic [WORD_W-1:0] word_sh;

  assign last_bit = (cnt == CW'(FRAME_BITS - 1));
  assign pre1_end = (cnt == CW'(PRE1_LEN - 1));
  assign pop      = sym_stb && (fld == FLD_DATA) && (widx == WIW'(WORD_W - 1));
  assign take     = sym_stb && (((fld == FLD_TOGGLE) && pre1_end) ||
                                ((fld == FLD_DATA) && last_bit && frame_avail));

  assign sync_sh = SYNC_WORD << cnt;
  assign word_sh = rd_word << widx;

  always_comb begin
    case (fld)
      FLD_TOGGLE: sym_bit = cnt[0];
      FLD_SYNC:   sym_bit = sync_sh[31];
      FLD_DATA:   sym_bit = word_sh[WORD_W-1];
      default:    sym_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld  <= FLD_IDLE;
      cnt  <= '0;
      widx <= '0;
    end else if (sym_stb) begin
      case (fld)
        FLD_IDLE: if (frame_avail) fld <= FLD_LEAD;
        FLD_LEAD: begin
          fld <= FLD_ZERO;
          cnt <= '0;
        end
        FLD_ZERO:
          if (cnt == CW'(PRE0_LEN - 1)) begin
            fld <= FLD_TOGGLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        FLD_TOGGLE:
          if (pre1_end) begin
            fld <= FLD_SYNC;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        FLD_SYNC:
          if (cnt == CW'(31)) begin
            fld  <= FLD_DATA;
            cnt  <= '0;
            widx <= '0;
          end else cnt <= cnt + 1'b1;
        FLD_DATA: begin
          widx <= (widx == WIW'(WORD_W - 1)) ? '0 : widx + 1'b1;
          if (last_bit) begin
            fld <= frame_avail ? FLD_SYNC : FLD_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: fld <= FLD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_assembler.sv
module burst_assembler
  import burst_asm_pkg::*;
#(
  parameter int          WORD_W      = 16,
  parameter int          FRAME_WORDS = 65,
  parameter int          BUF_FRAMES  = 7,
  parameter int          PRE0_LEN    = 800,
  parameter int          PRE1_LEN    = 800,
  parameter logic [31:0] SYNC_WORD   = 32'h1ACFFC1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              sym_stb,
  input  logic              tx_force,
  output logic              sym_bit,
  output logic              tx_en,
  output logic [2:0]        field
);
  logic              pop, take, frame_avail;
  logic [WORD_W-1:0] rd_word;
  fld_e              fld;

  burst_fifo #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .BUF_FRAMES(BUF_FRAMES)
  ) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(in_data),
    .pop(pop), .rd_word(rd_word), .take(take), .frame_avail(frame_avail)
  );

  burst_seq #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS),
    .PRE0_LEN(PRE0_LEN), .PRE1_LEN(PRE1_LEN), .SYNC_WORD(SYNC_WORD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .frame_avail(frame_avail),
    .rd_word(rd_word), .pop(pop), .take(take), .fld(fld), .sym_bit(sym_bit)
  );

  assign field = fld;
  assign tx_en = (fld != FLD_IDLE) || tx_force;
endmodule

// File: rtl/burst_assembler_chk.sv
module burst_assembler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sym_stb,
  input logic       tx_force,
  input logic       sym_bit,
  input logic       tx_en,
  input logic [2:0] field
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> ($stable(field) && $stable(sym_bit)));

  p_txen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en == ((field != 3'd0) || tx_force));

  p_lead_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && field == 3'd1) |=> (field == 3'd2));

  p_zero_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (field == 3'd2 || field == 3'd1 || field == 3'd0) |-> !sym_bit);

  p_idle_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && field == 3'd0) |=> (field == 3'd0 || field == 3'd1));

  p_data_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && field == 3'd5) |=> (field == 3'd5 || field == 3'd4 || field == 3'd0));

  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !sym_stb) |=> !in_ready);

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field <= 3'd5);
endmodule

bind burst_assembler burst_assembler_chk u_chk (.*);

// File: tb/burst_assembler_bench.sv
module burst_assembler_bench;
  localparam int          WW   = 4;
  localparam int          FWD  = 3;
  localparam int          NBF  = 2;
  localparam int          P0   = 4;
  localparam int          P1   = 4;
  localparam int          FB   = WW * FWD;
  localparam logic [31:0] SYNC = 32'h1ACFFC1D;
  localparam logic [FB-1:0] PAY_TAB [4] = '{12'hA5C, 12'h000, 12'hFFF, 12'h3C9};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WW-1:0] in_data = '0;
  logic          sym_stb = 1'b0;
  logic          tx_force = 1'b0;
  logic          sym_bit, tx_en;
  logic [2:0]    field;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  burst_assembler #(
    .WORD_W(WW), .FRAME_WORDS(FWD), .BUF_FRAMES(NBF),
    .PRE0_LEN(P0), .PRE1_LEN(P1), .SYNC_WORD(SYNC)
  ) u_burst_assembler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sym_stb(sym_stb), .tx_force(tx_force),
    .sym_bit(sym_bit), .tx_en(tx_en), .field(field)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic eb, input logic [2:0] ef, input logic ee, input string tag);
    @(negedge clk); sym_stb = 1'b1;
    @(negedge clk); sym_stb = 1'b0;
    chk({tag, " bit"}, 32'(sym_bit), 32'(eb));
    chk({tag, " field"}, 32'(field), 32'(ef));
    chk({tag, " tx_en"}, 32'(tx_en), 32'(ee));
  endtask

  task automatic push(input logic [WW-1:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic push_frame(input logic [FB-1:0] p);
    for (int k = 0; k < FWD; k++) push(p[FB-1-k*WW -: WW]);
  endtask

  task automatic burst(input logic [FB-1:0] p, input bit first, input bit hold_last);
    if (first) begin
      step(1'b0, 3'd1, 1'b1, "R7 lead");
      for (int i = 0; i < P0; i++) step(1'b0, 3'd2, 1'b1, "R2 zeros");
      for (int i = 0; i < P1; i++) step(i[0], 3'd3, 1'b1, "R2 toggle");
    end
    for (int i = 0; i < 32; i++)
      step(SYNC[31-i], 3'd4, 1'b1, (first || i > 0) ? "R2 sync" : "R4 follow-on sync");
    repeat (3) @(negedge clk);
    chk("R8 hold field", 32'(field), 32'd4);
    chk("R8 hold bit", 32'(sym_bit), 32'(SYNC[0]));
    for (int i = 0; i < FB - (hold_last ? 1 : 0); i++)
      step(p[FB-1-i], 3'd5, 1'b1, "R3 payload");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 field", 32'(field), 32'd0);
    chk("R1 bit", 32'(sym_bit), 32'd0);
    chk("R1 tx_en", 32'(tx_en), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);

    tx_force = 1'b1;
    @(negedge clk);
    chk("R10 forced tx_en", 32'(tx_en), 32'd1);
    chk("R10 field idle", 32'(field), 32'd0);
    tx_force = 1'b0;
    @(negedge clk);
    chk("R10 released tx_en", 32'(tx_en), 32'd0);

    for (int t = 0; t < 4; t++) begin
      push_frame(PAY_TAB[t]);
      if (t == 0) begin
        repeat (4) @(negedge clk);
        chk("R8 no strobe no start", 32'(field), 32'd0);
      end
      burst(PAY_TAB[t], 1'b1, 1'b0);
      step(1'b0, 3'd0, 1'b0, "R5 burst end");
    end

    push(4'h5); push(4'hA);
    step(1'b0, 3'd0, 1'b0, "R6 partial frame");
    push(4'h3);
    burst(12'h5A3, 1'b1, 1'b0);
    step(1'b0, 3'd0, 1'b0, "R5 end after R6");

    push_frame(12'h9E1);
    push_frame(12'h2B7);
    chk("R9 full not ready", 32'(in_ready), 32'd0);
    @(negedge clk); in_valid = 1'b1; in_data = 4'hF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R9 still full", 32'(in_ready), 32'd0);
    burst(12'h9E1, 1'b1, 1'b0);
    burst(12'h2B7, 1'b0, 1'b0);
    push(4'h4);
    step(1'b0, 3'd0, 1'b0, "R5 late frame closes burst");
    push(4'hD); push(4'h8);
    burst(12'h4D8, 1'b1, 1'b0);
    step(1'b0, 3'd0, 1'b0, "R5 end");

    push_frame(12'h6D4);
    push(4'hC); push(4'h1);
    burst(12'h6D4, 1'b1, 1'b1);
    push(4'h8);
    step(1'b0, 3'd5, 1'b1, "R3 last payload bit");
    burst(12'hC18, 1'b0, 1'b0);
    step(1'b0, 3'd0, 1'b0, "R5 final end");

    tx_force = 1'b1;
    @(negedge clk);
    chk("R10 forced after burst", 32'(tx_en), 32'd1);
    tx_force = 1'b0;

    finish_run();
  end
endmodule